// File: doc/BRIEF.md
# Temperature Restart Wakeup Controller

This block watches a low-power temperature threshold flag while the processor sits in its deepest stop mode. Software first writes two control bits: one enables the detector and the other names the side of the normal band on which the device has gone out of range, either too cold or too hot. Software then issues a stop request. While the block is stopped, it waits for the flag to show that the temperature has come back into the normal band. When that happens, it raises a one-cycle wakeup and holds a device reset request for a fixed number of cycles. Leaving stop by this path always restarts the device. Execution never resumes.

The raw flag is high when the temperature is above the comparator threshold. It passes through a synchronizer inside the block. Only a fresh edge in the chosen direction, seen while stopped, counts as a return to range. When direction is 0 (cold guard) that edge is a rise. When direction is 1 (hot guard) it is a fall. Edges seen before stop are dropped and not stored. The reset request clears both control bits, which puts the block back to idle.

Top module: `tempRestartCtrl`

## Requirements
- R1: After reset, `ctrlBits` is 0 and `wakeup`, `resetReq` and `inStop` are all low.
- R2: When the block is not stopped and not resetting, a write with `cfgWrEn` updates `ctrlBits` at the next clock edge. Bit 0 is the enable and bit 1 is the direction.
- R3: `stopReq` moves the block into stop, with `inStop` high one cycle later, only when enable is 1 and the enable has been in place for at least one cycle. With enable 0, `stopReq` has no effect.
- R4: With direction 0, a rise of `threshIn` while stopped makes `wakeup` high on the third clock edge after the change. `wakeup` stays high for exactly one cycle.
- R5: With direction 1, a fall of `threshIn` while stopped makes `wakeup` high on the third clock edge after the change. `wakeup` stays high for exactly one cycle.
- R6: While stopped, an edge of `threshIn` opposite to the selected direction produces no wakeup, and the block stays in stop.
- R7: An edge in the selected direction that happens before stop is entered is not stored. No wakeup follows once stop is entered.
- R8: `resetReq` rises in the same cycle as `wakeup` and stays high for exactly 4 cycles. `inStop` is low during that time.
- R9: When `resetReq` ends, `ctrlBits` reads 0 and the block is idle, so a following `stopReq` has no effect.
- R10: Writes while stopped are ignored, and `ctrlBits` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control write strobe |
| cfgWrData | input | 2 | Control write data: bit 0 enable, bit 1 direction |
| stopReq | input | 1 | Request to enter deep stop |
| threshIn | input | 1 | Raw threshold flag, high when temperature is above the threshold |
| wakeup | output | 1 | One-cycle wakeup on return to the normal band |
| resetReq | output | 1 | Device reset request, held 4 cycles |
| inStop | output | 1 | High while the block waits in stop |
| ctrlBits | output | 2 | Current control bits |

## Verification
A change of `threshIn` made between clock edges reaches `wakeup` and `resetReq` on the third rising edge. Two edges are spent in the synchronizer and one in the state register. `resetReq` then drops on the seventh edge, and the cleared control bits appear on that same edge. `ctrlBits` follows a write one edge after it is sampled, and `inStop` follows a stop request one edge after it is sampled. The bench drives every input on the falling edge and counts rising edges from that point. It samples on the falling edge after the edge on which each result is due, and it also checks the cycles just before that edge for the absence of the result. The sweep covers both directions and both starting flag levels, so matching and opposite first edges are both exercised.

// File: rtl/tempRestartPkg.sv
package tempRestartPkg;

  localparam int CFG_W       = 2;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_DIR_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_STOPPED,
    ST_WAKE_RESET
  } trwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic cfgClear;
    logic holdClear;
    logic holdStep;
  } trwStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic cfgEn;
    logic wakeEdge;
    logic holdDone;
  } trwStatus_t;

endpackage

// File: rtl/trwSync.sv
module trwSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= 1'b0;
        else       stageQ <= dIn;
      end
      assign dOut = stageQ;
    end else begin : g_chain
      logic [STAGES-1:0] chainQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], dIn};
      end
      assign dOut = chainQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/trwDatapath.sv
module trwDatapath
  import tempRestartPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_HOLD  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWrData,
  input  trwStrobe_t       strobe,
  input  logic             threshRaw,
  output trwStatus_t       status,
  output logic [CFG_W-1:0] ctrlBits
);

  localparam int CNT_W = (RESET_HOLD > 1) ? $clog2(RESET_HOLD) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RESET_HOLD - 1);

  logic             threshSync;
  logic             threshPrevQ;
  logic [CFG_W-1:0] cfgQ;
  logic [CNT_W-1:0] holdCntQ;
  logic             riseSeen;
  logic             fallSeen;

  trwSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (threshRaw),
    .dOut (threshSync)
  );

  // one extra flop for edge qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threshPrevQ <= 1'b0;
    else       threshPrevQ <= threshSync;
  end

  assign riseSeen = threshSync & ~threshPrevQ;
  assign fallSeen = ~threshSync & threshPrevQ;

  // control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgQ <= '0;
    else if (strobe.cfgClear) cfgQ <= '0;
    else if (strobe.cfgLoad)  cfgQ <= cfgWrData;
  end

  // reset hold counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdCntQ <= '0;
    else if (strobe.holdClear) holdCntQ <= '0;
    else if (strobe.holdStep)  holdCntQ <= holdCntQ + 1'b1;
  end

  assign status.cfgEn    = cfgQ[CFG_EN_BIT];
  assign status.wakeEdge = cfgQ[CFG_DIR_BIT] ? fallSeen : riseSeen;
  assign status.holdDone = (holdCntQ == HOLD_LAST);
  assign ctrlBits        = cfgQ;

endmodule

// File: rtl/trwControl.sv
module trwControl
  import tempRestartPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       stopReq,
  input  trwStatus_t status,
  output trwStrobe_t strobe,
  output logic       wakeup,
  output logic       resetReq,
  output logic       inStop
);

  trwState_e stateQ;
  trwState_e stateNxt;
  logic      wakeupQ;

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strobe.cfgLoad = cfgWrEn;
        if (status.cfgEn) stateNxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (!status.cfgEn) begin
          strobe.cfgLoad = cfgWrEn;
          stateNxt       = ST_IDLE;
        end else if (stopReq) begin
          stateNxt = ST_STOPPED;
        end else begin
          strobe.cfgLoad = cfgWrEn;
        end
      end
      ST_STOPPED: begin
        if (status.wakeEdge) begin
          stateNxt         = ST_WAKE_RESET;
          strobe.holdClear = 1'b1;
        end
      end
      ST_WAKE_RESET: begin
        strobe.holdStep = 1'b1;
        if (status.holdDone) begin
          strobe.cfgClear = 1'b1;
          stateNxt        = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      wakeupQ <= 1'b0;
    end else begin
      stateQ  <= stateNxt;
      wakeupQ <= (stateQ == ST_STOPPED) && status.wakeEdge;
    end
  end

  assign wakeup   = wakeupQ;
  assign resetReq = (stateQ == ST_WAKE_RESET);
  assign inStop   = (stateQ == ST_STOPPED);

endmodule

// File: rtl/tempRestartCtrl.sv
module tempRestartCtrl
  import tempRestartPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_HOLD  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  logic       stopReq,
  input  logic       threshIn,
  output logic       wakeup,
  output logic       resetReq,
  output logic       inStop,
  output logic [1:0] ctrlBits
);

  trwStrobe_t strobe;
  trwStatus_t status;

  trwDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .RESET_HOLD  (RESET_HOLD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .threshRaw (threshIn),
    .status    (status),
    .ctrlBits  (ctrlBits)
  );

  trwControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .stopReq  (stopReq),
    .status   (status),
    .strobe   (strobe),
    .wakeup   (wakeup),
    .resetReq (resetReq),
    .inStop   (inStop)
  );

endmodule

// File: rtl/trwChecker.sv
module trwChecker #(
  parameter int RESET_HOLD = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       stopReq,
  input logic       wakeup,
  input logic       resetReq,
  input logic       inStop,
  input logic [1:0] ctrlBits
);

  logic [15:0] holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         holdRun <= '0;
    else if (resetReq) holdRun <= holdRun + 16'd1;
    else               holdRun <= '0;
  end

  p_stop_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inStop) |-> ($past(ctrlBits[0]) && $past(stopReq)));

  p_wake_from_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeup |-> $past(inStop));

  p_wake_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakeup |=> !wakeup);

  p_reset_with_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> wakeup);

  p_hold_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> (holdRun == 16'(RESET_HOLD)));

  p_stop_reset_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inStop && resetReq));

  p_bits_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> (ctrlBits == 2'b00));

  p_bits_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inStop && $past(inStop)) |-> $stable(ctrlBits));

endmodule

bind tempRestartCtrl trwChecker #(.RESET_HOLD(RESET_HOLD)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stopReq  (stopReq),
  .wakeup   (wakeup),
  .resetReq (resetReq),
  .inStop   (inStop),
  .ctrlBits (ctrlBits)
);

// File: tb/tempRestartCtrl_test.sv
module tempRestartCtrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgWrData = 2'b00;
  logic       stopReq = 1'b0;
  logic       threshIn = 1'b0;
  logic       wakeup;
  logic       resetReq;
  logic       inStop;
  logic [1:0] ctrlBits;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tempRestartCtrl uut (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .stopReq   (stopReq),
    .threshIn  (threshIn),
    .wakeup    (wakeup),
    .resetReq  (resetReq),
    .inStop    (inStop),
    .ctrlBits  (ctrlBits)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cfgWrEn = 1'b0;
    stopReq = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic writeCfg(logic en, logic dir);
    cfgWrEn = 1'b1;
    cfgWrData = {dir, en};
    cyc(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic stopPulse();
    stopReq = 1'b1;
    cyc(1);
    stopReq = 1'b0;
  endtask

  // threshold already flipped at this negedge
  task automatic expectWake(logic dir);
    string wr;
    wr = dir ? "R5" : "R4";
    for (int i = 0; i < 2; i++) begin
      cyc(1);
      chk(wr, {7'd0, wakeup}, 8'd0);
    end
    cyc(1);
    chk(wr, {7'd0, wakeup}, 8'd1);
    chk("R8", {7'd0, resetReq}, 8'd1);
    chk("R8", {7'd0, inStop}, 8'd0);
    cyc(1);
    chk(wr, {7'd0, wakeup}, 8'd0);
    chk("R8", {7'd0, resetReq}, 8'd1);
    cyc(2);
    chk("R8", {7'd0, resetReq}, 8'd1);
    cyc(1);
    chk("R8", {7'd0, resetReq}, 8'd0);
    chk("R9", {6'd0, ctrlBits}, 8'd0);
    stopPulse();
    chk("R9", {7'd0, inStop}, 8'd0);
  endtask

  task automatic sweepCase(logic dir, logic startLvl);
    logic normalLvl;
    logic newLvl;
    normalLvl = ~dir;
    newLvl = ~startLvl;
    doReset();
    threshIn = startLvl;
    cyc(4);
    writeCfg(1'b1, dir);
    chk("R2", {6'd0, ctrlBits}, {6'd0, dir, 1'b1});
    cyc(1);
    stopPulse();
    chk("R3", {7'd0, inStop}, 8'd1);
    if (!startLvl) begin
      writeCfg(1'b0, ~dir);
      chk("R10", {6'd0, ctrlBits}, {6'd0, dir, 1'b1});
    end
    threshIn = newLvl;
    if (newLvl != normalLvl) begin
      for (int i = 0; i < 6; i++) begin
        cyc(1);
        chk("R6", {7'd0, wakeup}, 8'd0);
      end
      chk("R6", {7'd0, inStop}, 8'd1);
      threshIn = startLvl;
    end
    expectWake(dir);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in all requirements actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    doReset();
    // R1 reset state
    chk("R1", {6'd0, ctrlBits}, 8'd0);
    chk("R1", {7'd0, wakeup}, 8'd0);
    chk("R1", {7'd0, resetReq}, 8'd0);
    chk("R1", {7'd0, inStop}, 8'd0);

    // R3: stop ignored with enable clear
    writeCfg(1'b0, 1'b1);
    chk("R2", {6'd0, ctrlBits}, 8'd2);
    cyc(1);
    stopPulse();
    chk("R3", {7'd0, inStop}, 8'd0);
    threshIn = 1'b1;
    cyc(4);
    threshIn = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R3", {7'd0, wakeup | resetReq}, 8'd0);
    end

    // sweep direction and starting level
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        sweepCase(d[0], s[0]);
      end
    end

    // R7: edge before stop is not stored
    doReset();
    threshIn = 1'b0;
    cyc(4);
    writeCfg(1'b1, 1'b0);
    cyc(1);
    threshIn = 1'b1;
    cyc(5);
    stopPulse();
    chk("R7", {7'd0, inStop}, 8'd1);
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R7", {7'd0, wakeup}, 8'd0);
    end
    chk("R7", {7'd0, inStop}, 8'd1);
    threshIn = 1'b0;
    cyc(4);
    chk("R6", {7'd0, inStop}, 8'd1);
    threshIn = 1'b1;
    expectWake(1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule